// File: doc/BRIEF.md
# Two-Way Instruction Cache with Line Locking

This block is a 1-Kbyte instruction cache placed between a processor fetch port and a slower memory port. It is organised as two ways of 32 sets, and each line carries four 32-bit words. When a fetch hits, the word comes back in the cycle after the request is accepted. When a fetch misses, the block reads the whole line from memory one word at a time, starting at word 0 and counting upwards. Once the last word is stored, the block returns the requested word.

Software can make selected code stay in the cache. While `lock_en` is high at the moment a fetch is accepted, the line that this fetch fills is marked locked. A locked line is never chosen for replacement, and the invalidate-all pulse leaves it alone. If both ways of a set are already locked, a miss in that set reads only the requested word from memory and writes nothing into the cache.

Both the fetch side and the memory side use valid/ready handshakes. A request is taken only when `req_valid` and `req_ready` are both high at a clock edge. The block serves one request at a time, and `req_ready` stays low until the response has been consumed. A response remains on `resp_valid`/`resp_data` without change until `resp_ready` is high at an edge. A memory request keeps its address stable until `mem_req_ready` accepts it. Read data returns on `mem_rsp_valid`, a single-cycle strobe that the cache always accepts.

Top module: `icl_cache_lock2w`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0 and `mem_req_valid` is 0, and every line is invalid and unlocked.
- R2: A fetch that hits raises `resp_valid` in the cycle after acceptance, with no memory read.
- R3: `resp_valid` and `resp_data` hold steady while `resp_ready` is low, and the response is retired at the first edge where `resp_ready` is high.
- R4: A refilling miss issues exactly four memory reads to line base + 0, 4, 8 and 12, in that order. Every memory address has bits [1:0] equal to 0.
- R5: The address is split as follows: bits [3:2] select the word, bits [8:4] select the set, and bits [31:9] are the tag. The returned data equals the memory word at the address with bits [1:0] cleared. After a refill, every word of that line hits.
- R6: A line filled by a fetch accepted while `lock_en` is 1 is locked and is never replaced. In a set where one way is locked, a miss replaces the other way even when that other way was used more recently.
- R7: When both ways of a set are locked, a miss issues exactly one memory read, to the requested word, and allocates nothing, so repeating the fetch misses again.
- R8: The victim is an invalid way if one exists (way 0 first). Otherwise it is the only unlocked way. Otherwise it is the least recently used way.
- R9: Both hits and fills mark the accessed way as most recently used.
- R10: A one-cycle pulse on `inv_all` invalidates every unlocked line and leaves locked lines valid.
- R11: `mem_req_valid` stays high with a stable `mem_req_addr` until `mem_req_ready` is 1 at an edge.
- R12: `req_ready` is low whenever a response is pending or a memory request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Cache can accept a fetch |
| req_addr | input | 32 | Fetch byte address |
| resp_valid | output | 1 | Fetch data valid |
| resp_ready | input | 1 | Fetcher takes the data |
| resp_data | output | 32 | Fetched instruction word |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Word-aligned memory read address |
| mem_rsp_valid | input | 1 | Memory read data strobe |
| mem_rsp_data | input | 32 | Memory read data |
| lock_en | input | 1 | Lines filled by fetches accepted now become locked |
| inv_all | input | 1 | Invalidate all unlocked lines |

## Verification
The main function is tested with three fetch patterns. Repeated fetches within one line separate a hit, which makes no memory read and answers after one cycle, from a refill, which makes four ordered reads. A third tag mapped to a full set shows which way was evicted, and this confirms that a hit in between updated the recency bit. Lock patterns set a locked way against a more recently used unlocked way, then fill both ways with locked lines. Together they separate "skip the locked way" from "bypass with a single read and no allocation". An invalidate pulse followed by refetches of a locked line and an unlocked line shows that only unlocked state is cleared.

// File: rtl/icl_pkg.sv
package icl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RESP  = 2'd1,
    ST_MREQ  = 2'd2,
    ST_MWAIT = 2'd3
  } icl_state_e;
endpackage

// File: rtl/icl_tag_store.sv
module icl_tag_store #(
  parameter int SETS  = 32,
  parameter int TAG_W = 23,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] lk_idx,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [1:0]       lk_hit,
  output logic [1:0]       lk_valid,
  output logic [1:0]       lk_lock,
  output logic             lk_lru,
  input  logic             fill_en,
  input  logic             fill_way,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  input  logic             fill_lock,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic [IDX_W-1:0] touch_idx,
  input  logic             inv_all
);
  logic [SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  lck_q;
    logic [TAG_W-1:0] tag_q [SETS];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= '0;
        lck_q <= '0;
      end else begin
        for (int s = 0; s < SETS; s++) begin
          if (fill_en && fill_way == w[0] && fill_idx == IDX_W'(s)) begin
            vld_q[s] <= 1'b1;
            lck_q[s] <= fill_lock;
          end else if (inv_all && !lck_q[s]) begin
            vld_q[s] <= 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == w[0]) tag_q[fill_idx] <= fill_tag;
    end

    assign lk_valid[w] = vld_q[lk_idx];
    assign lk_lock[w]  = lck_q[lk_idx];
    assign lk_hit[w]   = vld_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lru_q <= '0;
    end else if (fill_en) begin
      lru_q[fill_idx] <= ~fill_way;
    end else if (touch_en) begin
      lru_q[touch_idx] <= ~touch_way;
    end
  end

  assign lk_lru = lru_q[lk_idx];
endmodule

// File: rtl/icl_data_store.sv
module icl_data_store #(
  parameter int SETS   = 32,
  parameter int WORDS  = 4,
  parameter int WORD_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int OFF_W = $clog2(WORDS)
) (
  input  logic                   clk,
  input  logic                   wr_en,
  input  logic                   wr_way,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [OFF_W-1:0]       wr_off,
  input  logic [WORD_W-1:0]      wr_data,
  input  logic [IDX_W-1:0]       rd_idx,
  input  logic [OFF_W-1:0]       rd_off,
  output logic [1:0][WORD_W-1:0] rd_word
);
  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [WORD_W-1:0] mem_q [SETS*WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_way == w[0]) mem_q[{wr_idx, wr_off}] <= wr_data;
    end

    assign rd_word[w] = mem_q[{rd_idx, rd_off}];
  end
endmodule

// File: rtl/icl_victim.sv
module icl_victim (
  input  logic [1:0] valid,
  input  logic [1:0] lock,
  input  logic       lru,
  output logic       way,
  output logic       none
);
  always_comb begin
    none = lock[0] && lock[1];
    if (!valid[0])                way = 1'b0;
    else if (!valid[1])           way = 1'b1;
    else if (lock[0] && !lock[1]) way = 1'b1;
    else if (lock[1] && !lock[0]) way = 1'b0;
    else                          way = lru;
  end
endmodule

// File: rtl/icl_cache_lock2w.sv
module icl_cache_lock2w #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int SETS   = 32,
  parameter int WORDS  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [WORD_W-1:0] resp_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [WORD_W-1:0] mem_rsp_data,
  input  logic              lock_en,
  input  logic              inv_all
);
  import icl_pkg::*;

  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - OFF_W - IDX_W;
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORDS - 1);

  icl_state_e state_q;
  logic [TAG_W-1:0]  a_tag_q;
  logic [IDX_W-1:0]  a_idx_q;
  logic [OFF_W-1:0]  a_off_q;
  logic [OFF_W-1:0]  cnt_q;
  logic              a_lock_q, byp_q, vway_q;
  logic [WORD_W-1:0] resp_q;

  logic [OFF_W-1:0] in_off;
  logic [IDX_W-1:0] in_idx;
  logic [TAG_W-1:0] in_tag;
  logic             unused_lsb;
  assign in_off     = req_addr[2 +: OFF_W];
  assign in_idx     = req_addr[2 + OFF_W +: IDX_W];
  assign in_tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign unused_lsb = ^req_addr[1:0];

  logic [1:0] lk_hit, lk_valid, lk_lock;
  logic       lk_lru, look_hit, hit_way, vic_way, vic_none, acc;
  logic [1:0][WORD_W-1:0] rd_word;
  logic       wr_en, fill_en;

  assign look_hit = |lk_hit;
  assign hit_way  = lk_hit[1];
  assign acc      = req_valid && req_ready;
  assign wr_en    = (state_q == ST_MWAIT) && mem_rsp_valid && !byp_q;
  assign fill_en  = wr_en && (cnt_q == LAST_OFF);

  icl_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .lk_idx(in_idx), .lk_tag(in_tag),
    .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_lock(lk_lock), .lk_lru(lk_lru),
    .fill_en(fill_en), .fill_way(vway_q), .fill_idx(a_idx_q),
    .fill_tag(a_tag_q), .fill_lock(a_lock_q),
    .touch_en(acc && look_hit), .touch_way(hit_way), .touch_idx(in_idx),
    .inv_all(inv_all)
  );

  icl_data_store #(.SETS(SETS), .WORDS(WORDS), .WORD_W(WORD_W)) u_data (
    .clk(clk), .wr_en(wr_en), .wr_way(vway_q), .wr_idx(a_idx_q),
    .wr_off(cnt_q), .wr_data(mem_rsp_data),
    .rd_idx(in_idx), .rd_off(in_off), .rd_word(rd_word)
  );

  icl_victim u_vic (
    .valid(lk_valid), .lock(lk_lock), .lru(lk_lru),
    .way(vic_way), .none(vic_none)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      a_tag_q  <= '0;
      a_idx_q  <= '0;
      a_off_q  <= '0;
      cnt_q    <= '0;
      a_lock_q <= 1'b0;
      byp_q    <= 1'b0;
      vway_q   <= 1'b0;
      resp_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (acc) begin
          if (look_hit) begin
            resp_q  <= rd_word[hit_way];
            state_q <= ST_RESP;
          end else begin
            a_tag_q  <= in_tag;
            a_idx_q  <= in_idx;
            a_off_q  <= in_off;
            a_lock_q <= lock_en;
            byp_q    <= vic_none;
            vway_q   <= vic_way;
            cnt_q    <= vic_none ? in_off : '0;
            state_q  <= ST_MREQ;
          end
        end
        ST_MREQ: if (mem_req_ready) state_q <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_valid) begin
          if (cnt_q == a_off_q) resp_q <= mem_rsp_data;
          if (byp_q || cnt_q == LAST_OFF) begin
            state_q <= ST_RESP;
          end else begin
            cnt_q   <= cnt_q + OFF_W'(1);
            state_q <= ST_MREQ;
          end
        end
        ST_RESP: if (resp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == ST_IDLE);
  assign resp_valid    = (state_q == ST_RESP);
  assign resp_data     = resp_q;
  assign mem_req_valid = (state_q == ST_MREQ);
  assign mem_req_addr  = {a_tag_q, a_idx_q, cnt_q, 2'b00};
endmodule

// File: rtl/icl_checker.sv
module icl_checker #(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              resp_valid,
  input logic              resp_ready,
  input logic [WORD_W-1:0] resp_data,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              look_hit
);
  a_r2_hit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && look_hit) |=> resp_valid);

  a_r2_miss_goes_to_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !look_hit) |=> (mem_req_valid && !resp_valid));

  a_r3_resp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_data)));

  a_r4_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[1:0] == 2'b00));

  a_r11_mreq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  a_r12_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid || mem_req_valid) |-> !req_ready);
endmodule

bind icl_cache_lock2w icl_checker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_data(resp_data),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .look_hit(look_hit)
);

// File: tb/test_icl_cache_lock2w.sv
module test_icl_cache_lock2w;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, resp_ready = 1'b1;
  logic [31:0] req_addr = '0;
  logic        req_ready, resp_valid, mem_req_valid;
  logic [31:0] resp_data, mem_req_addr;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        lock_en = 1'b0, inv_all = 1'b0;

  always #2 clk = ~clk;

  icl_cache_lock2w i_icl_cache_lock2w (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_data(resp_data), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .lock_en(lock_en), .inv_all(inv_all)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return {a[31:2], 2'b00} ^ 32'hC3A5_0F1E;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected < 100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  // memory model: stalls every third cycle, answers two cycles after acceptance
  int          nreads = 0, pend = 0, tick = 0;
  logic [31:0] paddr = '0;
  logic [31:0] alog [8];
  always @(negedge clk) begin
    if (mem_rsp_valid) mem_rsp_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = memf(paddr);
      end
    end
    tick++;
    mem_req_ready = (tick % 3 != 2);
    if (rst_n && mem_req_valid && mem_req_ready && pend == 0 && !mem_rsp_valid) begin
      alog[nreads % 8] = mem_req_addr;
      nreads++;
      paddr = mem_req_addr;
      pend = 2;
    end
  end

  task automatic fetch(input logic [31:0] a, input int hold,
                       output logic [31:0] d, output int reads, output int lat,
                       output int r0);
    r0 = nreads;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; resp_ready = (hold == 0);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!resp_valid) begin @(negedge clk); lat++; end
    d = resp_data;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(resp_valid && resp_data == d, "R3", "response held under back-pressure",
          resp_data, d);
    end
    resp_ready = 1'b1;
    @(negedge clk);
    chk(!resp_valid, "R3", "response retired", 32'(resp_valid), 32'd0);
    reads = nreads - r0;
  endtask

  // {inv_all before, lock_en, expected memory reads, address}
  localparam int NV = 21;
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, 1'b0, 3'd4, 32'h0000_0238},  // R8 invalid way0 first
    {1'b0, 1'b0, 3'd0, 32'h0000_0230},  // R5 other word of line hits
    {1'b0, 1'b0, 3'd4, 32'h0000_0434},  // R8 fill way1
    {1'b0, 1'b0, 3'd0, 32'h0000_023C},  // R9 hit marks way0 recent
    {1'b0, 1'b0, 3'd4, 32'h0000_0630},  // R8 evicts LRU (tag 2)
    {1'b0, 1'b0, 3'd0, 32'h0000_0234},  // R9 tag 1 survived
    {1'b0, 1'b0, 3'd4, 32'h0000_0430},  // R8 tag 2 was evicted
    {1'b0, 1'b0, 3'd4, 32'h8000_0230},  // R5 top tag bit differs
    {1'b0, 1'b0, 3'd4, 32'h0000_0EAC},  // other set
    {1'b0, 1'b0, 3'd0, 32'h0000_0EA0},
    {1'b0, 1'b1, 3'd4, 32'h0000_0850},  // R6 locked fill way0
    {1'b0, 1'b0, 3'd4, 32'h0000_0A50},  // way1
    {1'b0, 1'b0, 3'd4, 32'h0000_0C50},  // R6 replaces way1 though way0 is LRU
    {1'b0, 1'b0, 3'd0, 32'h0000_0858},  // R6 locked line resident
    {1'b1, 1'b0, 3'd0, 32'h0000_0854},  // R10 locked kept after invalidate
    {1'b0, 1'b0, 3'd4, 32'h0000_0C50},  // R10 unlocked dropped
    {1'b0, 1'b0, 3'd4, 32'h8000_0234},  // R10 set 3 dropped
    {1'b0, 1'b1, 3'd4, 32'h0000_1050},  // R6 second locked way
    {1'b0, 1'b0, 3'd1, 32'h0000_1258},  // R7 bypass one read
    {1'b0, 1'b1, 3'd1, 32'h0000_1258},  // R7 no allocation
    {1'b0, 1'b0, 3'd0, 32'h0000_105C}   // R6 both locked lines hit
  };

  initial begin
    logic [31:0] d, a;
    int reads, lat, r0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready in reset", 32'(req_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1", "req_ready after reset", 32'(req_ready), 32'd1);
    chk(!resp_valid, "R1", "resp_valid after reset", 32'(resp_valid), 32'd0);
    chk(!mem_req_valid, "R1", "mem_req_valid after reset", 32'(mem_req_valid), 32'd0);

    for (int v = 0; v < NV; v++) begin
      a = VEC[v][31:0];
      if (VEC[v][36]) begin
        @(negedge clk); inv_all = 1'b1;
        @(negedge clk); inv_all = 1'b0;
      end
      lock_en = VEC[v][35];
      fetch(a, 0, d, reads, lat, r0);
      lock_en = 1'b0;
      chk(d == memf(a), "R5", $sformatf("data vec %0d", v), d, memf(a));
      chk(reads == int'(VEC[v][34:32]), "R8", $sformatf("memory reads vec %0d", v),
          32'(reads), 32'(VEC[v][34:32]));
      if (VEC[v][34:32] == 3'd0)
        chk(lat == 1, "R2", $sformatf("hit latency vec %0d", v), 32'(lat), 32'd1);
      if (VEC[v][34:32] == 3'd4)
        for (int k = 0; k < 4; k++)
          chk(alog[(r0 + k) % 8] == {a[31:4], 4'b0} + 32'(4 * k), "R4",
              $sformatf("refill order vec %0d word %0d", v, k),
              alog[(r0 + k) % 8], {a[31:4], 4'b0} + 32'(4 * k));
      if (VEC[v][34:32] == 3'd1)
        chk(alog[r0 % 8] == {a[31:2], 2'b00}, "R7", $sformatf("bypass address vec %0d", v),
            alog[r0 % 8], {a[31:2], 2'b00});
    end

    // R3: hold a hit response for three cycles, then a miss response
    fetch(32'h0000_0854, 3, d, reads, lat, r0);
    chk(d == memf(32'h0000_0854), "R3", "held hit data", d, memf(32'h0000_0854));
    fetch(32'h0000_1A54, 2, d, reads, lat, r0);
    chk(d == memf(32'h0000_1A54), "R3", "held bypass data", d, memf(32'h0000_1A54));
    chk(reads == 1, "R7", "bypass while held", 32'(reads), 32'd1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule